// File: doc/BRIEF.md
# Clock Generator Control Register Slave

This block is the serial control port of a clock generator. It is an SMBus slave that holds eight 8-bit control bytes. Each output byte drives the enables, frequency selects and spread settings of the clock synthesiser next to it. The system clock oversamples SCL and SDA. SDA is only ever pulled low, through an output enable, and an external pull-up returns it high.

A write starts with the slave address. The master must then send two more bytes: a command byte and a byte count. The slave acknowledges both and discards their contents. Every data byte that follows goes into the next control byte, starting at byte 0 every time. A read returns the number of control bytes first, then bytes 0 through 7 in order.

Byte 5 has two parts. Its three low bits can be written. Its five high bits show the configuration strap pins, which the block samples once, on the first clock after power-up reset. The power-up defaults are loaded only by that reset. No bus event restores them.

Top module: `clkgen_ctl_smbus`

## Requirements
- R1: After reset the control bytes 0..7 read 0x80, 0x0B, 0x5F, 0x37, 0x00, {straps,3'b011}, 0x00 and 0x00. Byte 3 bit 6 is 0 after reset, which selects the 24 MHz SIO rate (1 selects 48 MHz).
- R2: A START followed by the 7-bit address DEV_ADDR and a direction bit is acknowledged. Any other address is not acknowledged, and every byte after it has no effect until the next START.
- R3: In a write, the first two bytes after the address are acknowledged, and their values reach no control byte.
- R4: In a write, the data bytes land in control bytes 0, 1, 2 and onward, in the order sent. Each new write transaction restarts at byte 0.
- R5: A ninth data byte and any later one in the same write are not acknowledged and change no control byte.
- R6: Byte 5 bits 7..3 hold strap_i[4..0], sampled on the first clock after reset. A later change on strap_i does not change them, and a bus write to byte 5 does not change them.
- R7: A read returns 0x08 first and then control bytes 0..7. After the master does not acknowledge a byte, the slave releases SDA.
- R8: sda_oe is asserted only in an acknowledge slot the slave owns or while the slave transmits a 0 bit. While the slave is idle, sda_oe is never asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Power-up reset, active low |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data sensed on the bus |
| sda_oe | output | 1 | 1 pulls SDA low |
| strap_i | input | STRAP_W | Configuration strap pins |
| cfg_o | output | NREG*8 | Control bytes; byte k sits at bits 8k+7..8k |

## Verification
The bound checker watches four things on every cycle. SDA stays released while the slave is idle. The write pointer never passes the last control byte. The control bytes change only while data bytes are being accepted. The latched straps never move once they are sampled. The directed scenarios cover what only whole transactions can show: the acknowledge on each bit slot, address rejection, the discarded command and count bytes, the overflow refusal and the order of the readback.

// File: rtl/clkgen_ctl_smbus.sv
module clkgen_ctl_smbus #(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int NREG = 8,
  parameter int STRAP_W = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scl_i,
  input  logic                sda_i,
  output logic                sda_oe,
  input  logic [STRAP_W-1:0]  strap_i,
  output logic [NREG*8-1:0]   cfg_o
);
  localparam int AW = $clog2(NREG);
  localparam int PW = $clog2(NREG + 1);
  localparam int IW = $clog2(NREG + 2);
  localparam int STRAP_REG = 5;
  localparam logic [PW-1:0] LAST_P = PW'(NREG);
  localparam logic [IW-1:0] LAST_I = IW'(NREG);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_CMD, S_CNT, S_DATA, S_READ} st_t;

  function automatic logic [7:0] dflt(int k);
    case (k)
      0: return 8'h80;
      1: return 8'h0B;
      2: return 8'h5F;
      3: return 8'h37;
      5: return 8'h03;
      default: return 8'h00;
    endcase
  endfunction

  logic [2:0] scl_p, sda_p;
  st_t state;
  logic [3:0] bitcnt;
  logic ack_slot, mnack, strap_done;
  logic [7:0] sh, tx, rd_cur;
  logic [PW-1:0] wr_ptr;
  logic [IW-1:0] rd_idx;
  logic [STRAP_W-1:0] strap_q;
  logic [7:0] regs [NREG];
  logic [7:0] cfg_b [NREG];

  wire scl_s = scl_p[1];
  wire sda_s = sda_p[1];
  wire scl_rise = scl_s & ~scl_p[2];
  wire scl_fall = ~scl_s & scl_p[2];
  wire start_c = scl_s & scl_p[2] & sda_p[2] & ~sda_p[1];
  wire stop_c  = scl_s & scl_p[2] & ~sda_p[2] & sda_p[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end

  always_comb
    for (int k = 0; k < NREG; k++) begin
      cfg_b[k] = (k == STRAP_REG) ? {strap_q, regs[k][7-STRAP_W:0]} : regs[k];
      cfg_o[8*k +: 8] = cfg_b[k];
    end

  assign rd_cur = (rd_idx == '0) ? 8'(NREG) :
                  (rd_idx <= LAST_I) ? cfg_b[AW'(rd_idx - 1'b1)] : 8'hFF;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= S_IDLE;
      bitcnt <= '0;
      ack_slot <= 1'b0;
      mnack <= 1'b0;
      sda_oe <= 1'b0;
      sh <= '0;
      tx <= '0;
      wr_ptr <= '0;
      rd_idx <= '0;
      strap_q <= '0;
      strap_done <= 1'b0;
      for (int k = 0; k < NREG; k++) regs[k] <= dflt(k);
    end else begin
      if (!strap_done) begin
        strap_q <= strap_i;
        strap_done <= 1'b1;
      end
      if (start_c) begin
        state <= S_ADDR;
        bitcnt <= '0;
        ack_slot <= 1'b0;
        sda_oe <= 1'b0;
      end else if (stop_c) begin
        state <= S_IDLE;
        ack_slot <= 1'b0;
        sda_oe <= 1'b0;
      end else if (state != S_IDLE) begin
        if (scl_rise) begin
          if (!ack_slot) begin
            sh <= {sh[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else
            mnack <= sda_s;
        end else if (scl_fall) begin
          if (!ack_slot && bitcnt == 4'd8) begin
            ack_slot <= 1'b1;
            bitcnt <= '0;
            sda_oe <= 1'b0;
            case (state)
              S_ADDR:
                if (sh[7:1] == DEV_ADDR) begin
                  sda_oe <= 1'b1;
                  state <= sh[0] ? S_READ : S_CMD;
                  rd_idx <= '0;
                end else
                  state <= S_IDLE;
              S_CMD: begin
                sda_oe <= 1'b1;
                state <= S_CNT;
              end
              S_CNT: begin
                sda_oe <= 1'b1;
                state <= S_DATA;
                wr_ptr <= '0;
              end
              S_DATA:
                if (wr_ptr < LAST_P) begin
                  sda_oe <= 1'b1;
                  regs[AW'(wr_ptr)] <= sh;
                  wr_ptr <= wr_ptr + 1'b1;
                end
              default: ;
            endcase
          end else if (ack_slot) begin
            ack_slot <= 1'b0;
            sda_oe <= 1'b0;
            if (state == S_READ) begin
              if (mnack)
                state <= S_IDLE;
              else begin
                tx <= rd_cur;
                sda_oe <= ~rd_cur[7];
                rd_idx <= rd_idx + 1'b1;
              end
            end
          end else if (state == S_READ) begin
            tx <= {tx[6:0], 1'b0};
            sda_oe <= ~tx[6];
          end
        end
      end
    end
endmodule

module clkgen_ctl_smbus_chk #(
  parameter int NREG = 8,
  parameter int STRAP_W = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 sda_oe,
  input logic [2:0]           st,
  input logic [$clog2(NREG+1)-1:0] wr_ptr,
  input logic                 strap_done,
  input logic [STRAP_W-1:0]   strap_q,
  input logic [NREG*8-1:0]    cfg_o
);
  localparam int PW = $clog2(NREG + 1);

  p_idle_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    st == 3'd0 |-> !sda_oe);

  p_ptr_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ptr <= PW'(NREG));

  p_cfg_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_done && $past(strap_done) && $past(st) != 3'd4) |-> $stable(cfg_o));

  p_strap_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_done && $past(strap_done)) |-> $stable(strap_q));
endmodule

bind clkgen_ctl_smbus clkgen_ctl_smbus_chk #(.NREG(NREG), .STRAP_W(STRAP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .st(state), .wr_ptr(wr_ptr),
  .strap_done(strap_done), .strap_q(strap_q), .cfg_o(cfg_o));

// File: tb/sim_clkgen_ctl_smbus.sv
module sim_clkgen_ctl_smbus;
  localparam int CLK_NS = 10;
  localparam int Q = 6;
  localparam logic [6:0] ADDR = 7'h69;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic [4:0] strap = 5'b10110;
  logic [63:0] cfg;
  wire sda_line = sda_m & ~sda_oe;

  int errors = 0, checks = 0;
  logic [7:0] exp_b [8];
  logic mon_en = 1'b0, oe_seen = 1'b0;

  always #(CLK_NS/2) clk = ~clk;
  always @(negedge clk) if (mon_en && sda_oe) oe_seen = 1'b1;

  clkgen_ctl_smbus u0 (.clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .strap_i(strap), .cfg_o(cfg));

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitq();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  function automatic logic [63:0] exp_cfg();
    logic [63:0] v;
    for (int k = 0; k < 8; k++) v[8*k +: 8] = exp_b[k];
    return v;
  endfunction

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; waitq();
    sda_m = 1'b0; waitq();
    scl_m = 1'b0; waitq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; waitq();
    scl_m = 1'b1; waitq();
    sda_m = 1'b1; waitq();
  endtask

  task automatic bit_out(input logic b);
    sda_m = b; waitq();
    scl_m = 1'b1; waitq();
    scl_m = 1'b0; waitq();
  endtask

  task automatic bit_in(output logic b);
    sda_m = 1'b1; waitq();
    scl_m = 1'b1; waitq();
    b = sda_line;
    scl_m = 1'b0; waitq();
  endtask

  task automatic wbyte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(b);
    ack = ~b;
  endtask

  task automatic rbyte(input logic nack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      bit_in(b);
      d[i] = b;
    end
    bit_out(nack);
  endtask

  task automatic t_reset();
    check("R1 reset bytes", cfg, 64'h0000_B300_375F_0B80);
    check("R1 sio rate default 24MHz", {63'd0, cfg[30]}, 64'd0);
    check("R6 straps in byte5", {59'd0, cfg[47:43]}, {59'd0, strap});
  endtask

  task automatic t_write();
    logic a;
    bus_start();
    wbyte({ADDR, 1'b0}, a); check("R2 address ack", {63'd0, a}, 64'd1);
    wbyte(8'hA5, a); check("R3 command ack", {63'd0, a}, 64'd1);
    wbyte(8'h03, a); check("R3 count ack", {63'd0, a}, 64'd1);
    wbyte(8'h11, a); wbyte(8'h22, a); wbyte(8'h33, a);
    check("R4 last data ack", {63'd0, a}, 64'd1);
    bus_stop();
    exp_b[0] = 8'h11; exp_b[1] = 8'h22; exp_b[2] = 8'h33;
    check("R4 R3 sequential store, cmd/count discarded", cfg, exp_cfg());
  endtask

  task automatic t_miss();
    logic a;
    oe_seen = 1'b0; mon_en = 1'b1;
    bus_start();
    wbyte({7'h12, 1'b0}, a); check("R2 foreign address not acked", {63'd0, a}, 64'd0);
    wbyte(8'h00, a); wbyte(8'h00, a); wbyte(8'hEE, a);
    bus_stop();
    mon_en = 1'b0;
    check("R2 foreign write no effect", cfg, exp_cfg());
    check("R8 bus never pulled while unaddressed", {63'd0, oe_seen}, 64'd0);
  endtask

  task automatic t_overflow();
    logic a;
    bus_start();
    wbyte({ADDR, 1'b0}, a); wbyte(8'h5A, a); wbyte(8'h08, a);
    for (int k = 0; k < 8; k++) wbyte(8'h40 + 8'(k), a);
    check("R4 eighth data byte acked", {63'd0, a}, 64'd1);
    wbyte(8'hC9, a);
    check("R5 ninth data byte not acked", {63'd0, a}, 64'd0);
    bus_stop();
    for (int k = 0; k < 8; k++) exp_b[k] = 8'h40 + 8'(k);
    exp_b[5] = {strap, 3'b101};
    check("R5 R4 full write, overflow dropped", cfg, exp_cfg());
  endtask

  task automatic t_strap();
    logic a;
    logic [4:0] orig = strap;
    strap = 5'b01001;
    bus_start();
    wbyte({ADDR, 1'b0}, a); wbyte(8'h00, a); wbyte(8'h06, a);
    for (int k = 0; k < 5; k++) wbyte(8'hA0 + 8'(k), a);
    wbyte(8'h00, a);
    bus_stop();
    for (int k = 0; k < 5; k++) exp_b[k] = 8'hA0 + 8'(k);
    exp_b[5] = {orig, 3'b000};
    check("R6 straps held against pin change and write", cfg, exp_cfg());
  endtask

  task automatic t_read();
    logic a;
    logic [7:0] d;
    bus_start();
    wbyte({ADDR, 1'b1}, a); check("R2 read address ack", {63'd0, a}, 64'd1);
    rbyte(1'b0, d); check("R7 count byte first", {56'd0, d}, 64'd8);
    for (int k = 0; k < 8; k++) begin
      rbyte(k == 7, d);
      check($sformatf("R7 readback byte %0d", k), {56'd0, d}, {56'd0, exp_b[k]});
    end
    check("R7 released after master nack", {63'd0, sda_oe}, 64'd0);
    bus_stop();
    check("R8 released after stop", {63'd0, sda_oe}, 64'd0);
  endtask

  initial begin
    repeat (20) @(posedge clk);
    if (errors == 0 || errors != 0) begin
      exp_b[0] = 8'h80; exp_b[1] = 8'h0B; exp_b[2] = 8'h5F; exp_b[3] = 8'h37;
      exp_b[4] = 8'h00; exp_b[5] = {strap, 3'b011}; exp_b[6] = 8'h00; exp_b[7] = 8'h00;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (30) @(posedge clk);
    #1;
    t_reset();
    t_write();
    t_miss();
    t_overflow();
    t_strap();
    t_read();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule